// File: doc/BRIEF.md
# SPI Word Deserializer

This block receives words from an SPI-style master that only transmits. The master drives an active-low select, a serial clock and one data line. The block collects the data bits into fixed 16-bit words. Each time a word is complete, the block places it on a parallel bus and raises a strobe for one system clock, so that a display controller or any other parallel consumer can take it. The block sends nothing back to the master.

The serial inputs are asynchronous to the block. Each one passes through a two-flop synchroniser. The rising edge of the serial clock is then detected in the system clock domain, and the system clock must run at least four times faster than the serial clock. The block has no byte framing. It counts sampled bits only within a select window, and every sixteenth bit completes a word. Because of this, the master can send one long stream of words under a single held select, or split a word into two 8-bit halves, and both arrive correctly. A window that closes before a word is complete leaves no trace.

Top module: `spi_word_deser`

## Requirements
- R1: A word is delivered only after exactly 16 data bits have been sampled within one select window. Fewer bits never raise the strobe.
- R2: When select goes active, the bit count and the collected bits are cleared, so bits from an earlier window never join a new word.
- R3: One bit is sampled on each rising edge of the serial clock while select is low (clock idles low). Bits arrive most significant first, so the first bit of a word lands in bit 15 of the output.
- R4: While select stays low, words may follow one another with no gap. Each one produces its own strobe, in the order received.
- R5: If select is released after fewer than 16 bits, no strobe occurs and the parallel output keeps its previous value.
- R6: Two 8-bit transfers sent under one continuous select produce the same single 16-bit word as one 16-bit transfer would.
- R7: The strobe is high for exactly one system clock per word. The parallel output changes only together with the strobe and holds its value in between.
- R8: Reset clears the parallel output to 0 and holds the strobe low.
- R9: The strobe and the new word appear on the outputs after the third system clock rising edge that follows the change of the serial clock pin for the 16th bit.
- R10: Serial clock edges while select is high sample nothing and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| spi_sck | input | 1 | Serial clock from the master; idles low |
| spi_sel_n | input | 1 | Active-low select from the master |
| spi_din | input | 1 | Serial data from the master |
| word_out | output | WORD_W (16) | Last completed word |
| word_stb | output | 1 | One-cycle pulse when word_out takes a new word |

## Verification
The bench targets four corner cases.

- A window closed after 15 bits. A design that emitted partial words would strobe, or would alter the output.
- A short abandoned window followed by a full one. A design that failed to clear on select would spread the stale bits into a shifted, wrong word.
- Clock toggling while select is idle. A design with no select gating would take the toggles as data.
- Back-to-back words and split byte pairs under one select. These expose a counter that does not wrap or that resets on byte boundaries.

A behavioural model predicts the strobe and the output word on every system clock, so an extra cycle of latency, a lost bit or a stretched strobe shows up as a mismatch at once.

// File: rtl/spi_word_deser.sv
module spi_word_deser #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_sel_n,
  input  logic              spi_din,
  output logic [WORD_W-1:0] word_out,
  output logic              word_stb
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [SYNC_STAGES-1:0] sck_sy, sel_sy, din_sy;
  logic                   sck_d;
  logic [CNT_W-1:0]       cnt;
  logic [WORD_W-1:0]      shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_sy <= '0;
      sel_sy <= '1;
      din_sy <= '0;
      sck_d  <= 1'b0;
    end else begin
      sck_sy <= {sck_sy[SYNC_STAGES-2:0], spi_sck};
      sel_sy <= {sel_sy[SYNC_STAGES-2:0], spi_sel_n};
      din_sy <= {din_sy[SYNC_STAGES-2:0], spi_din};
      sck_d  <= sck_sy[SYNC_STAGES-1];
    end
  end

  wire sck_now  = sck_sy[SYNC_STAGES-1];
  wire sel_now  = sel_sy[SYNC_STAGES-1];
  wire din_now  = din_sy[SYNC_STAGES-1];
  wire active   = ~sel_now;
  wire sck_rise = sck_now & ~sck_d;
  wire take     = sck_rise & active;
  wire [WORD_W-1:0] shifted = {shreg[WORD_W-2:0], din_now};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      shreg    <= '0;
      word_out <= '0;
      word_stb <= 1'b0;
    end else begin
      word_stb <= 1'b0;
      if (!active) begin
        cnt   <= '0;
        shreg <= '0;
      end else if (take) begin
        if (cnt == LAST) begin
          word_out <= shifted;
          word_stb <= 1'b1;
          cnt      <= '0;
          shreg    <= '0;
        end else begin
          shreg <= shifted;
          cnt   <= cnt + 1'b1;
        end
      end
    end
  end

  assert_stb_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> !word_stb);

  assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |-> $stable(word_out));

  assert_stb_after_full_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cnt != LAST) |=> !word_stb);

  assert_clear_on_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_now) |-> (cnt == '0 && shreg == '0));

  assert_idle_no_stb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_now |=> !word_stb);

endmodule

// File: tb/spi_word_deser_bench.sv
module spi_word_deser_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, sck = 1'b0, sel_n = 1'b1, din = 1'b0;
  logic [15:0] word;
  logic        stb;

  spi_word_deser u_spi_word_deser (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_sel_n(sel_n),
    .spi_din(din), .word_out(word), .word_stb(stb)
  );

  int checks = 0, fails = 0;
  bit done = 0, cmp_on = 0;
  logic [16:0] expq[$];
  logic [15:0] seen_q[$];
  int          m_cnt = 0;
  logic [15:0] m_sh = '0, m_word = '0;
  logic        m_prev_sck = 1'b0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(logic s, logic c, logic d);
    logic [16:0] e;
    logic ms;
    @(negedge clk);
    if (cmp_on && expq.size() == 3) begin
      e = expq.pop_front();
      check(stb === e[16] && word === e[15:0], "R9", "per-cycle stb/word",
            {15'b0, stb, word}, {15'b0, e});
    end
    if (stb === 1'b1) seen_q.push_back(word);
    sck = s; sel_n = c; din = d;
    ms = 1'b0;
    if (c) begin
      m_cnt = 0; m_sh = '0;
    end else if (s && !m_prev_sck) begin
      m_sh = {m_sh[14:0], d};
      m_cnt++;
      if (m_cnt == 16) begin
        m_word = m_sh; ms = 1'b1; m_cnt = 0; m_sh = '0;
      end
    end
    m_prev_sck = s;
    expq.push_back({ms, m_word});
  endtask

  task automatic idle(int n, logic c);
    for (int i = 0; i < n; i++) step(1'b0, c, 1'b0);
  endtask

  task automatic spi_bit(logic b);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, b);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, b);
  endtask

  task automatic send(logic [15:0] w, int nbits);
    for (int i = nbits - 1; i >= 0; i--) spi_bit(w[i]);
    idle(4, 1'b0);
  endtask

  task automatic do_reset();
    cmp_on = 0;
    rst_n = 1'b0;
    idle(5, 1'b1);
    check(word === 16'h0 && stb === 1'b0, "R8", "outputs in reset", {15'b0, stb, word}, 32'h0);
    expq.delete();
    m_cnt = 0; m_sh = '0; m_word = '0; m_prev_sck = 1'b0;
    expq.push_back(17'h0); expq.push_back(17'h0);
    rst_n = 1'b1;
    cmp_on = 1;
    idle(5, 1'b1);
  endtask

  int n0;

  initial begin
    do_reset();

    // R1 R3 R7: one full word, MSB first, single strobe
    seen_q.delete();
    idle(4, 1'b0); send(16'hA5C3, 16); idle(8, 1'b1);
    check(seen_q.size() == 1, "R1 R7", "strobe cycles for one word", seen_q.size(), 1);
    if (seen_q.size() > 0) check(seen_q[0] === 16'hA5C3, "R3", "word MSB first", seen_q[0], 16'hA5C3);

    // R5: 15 bits then release
    seen_q.delete();
    idle(4, 1'b0); send(16'h7FFF, 15); idle(8, 1'b1);
    check(seen_q.size() == 0, "R5", "no strobe on partial word", seen_q.size(), 0);
    check(word === 16'hA5C3, "R5", "output held after partial", word, 16'hA5C3);

    // R6: two bytes under one select
    seen_q.delete();
    idle(4, 1'b0); send(16'h003C, 8); send(16'h0096, 8); idle(8, 1'b1);
    check(seen_q.size() == 1, "R6", "byte pair strobes", seen_q.size(), 1);
    if (seen_q.size() > 0) check(seen_q[0] === 16'h3C96, "R6", "byte pair word", seen_q[0], 16'h3C96);

    // R4: back-to-back words under one select
    seen_q.delete();
    idle(4, 1'b0);
    for (int i = 0; i < 16; i++) spi_bit(16'h1234 >> (15 - i));
    for (int i = 0; i < 16; i++) spi_bit(16'hBEEF >> (15 - i));
    for (int i = 0; i < 16; i++) spi_bit(16'h0001 >> (15 - i));
    idle(8, 1'b1);
    check(seen_q.size() == 3, "R4", "stream strobe count", seen_q.size(), 3);
    if (seen_q.size() == 3) begin
      check(seen_q[0] === 16'h1234, "R4", "stream word 0", seen_q[0], 16'h1234);
      check(seen_q[1] === 16'hBEEF, "R4", "stream word 1", seen_q[1], 16'hBEEF);
      check(seen_q[2] === 16'h0001, "R4", "stream word 2", seen_q[2], 16'h0001);
    end

    // R2: abandoned 5 bits, then a fresh select
    seen_q.delete();
    idle(4, 1'b0); send(16'h001F, 5); idle(8, 1'b1);
    idle(4, 1'b0); send(16'h0F0F, 16); idle(8, 1'b1);
    check(seen_q.size() == 1, "R2", "strobes after reselect", seen_q.size(), 1);
    if (seen_q.size() > 0) check(seen_q[0] === 16'h0F0F, "R2", "word after reselect", seen_q[0], 16'h0F0F);

    // R10: clock toggles while deselected
    seen_q.delete();
    for (int i = 0; i < 20; i++) begin
      for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 1'b1);
      for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b1);
    end
    check(seen_q.size() == 0, "R10", "no strobe while deselected", seen_q.size(), 0);
    check(word === 16'h0F0F, "R10", "output unchanged while deselected", word, 16'h0F0F);
    idle(4, 1'b0); send(16'h8001, 16); idle(8, 1'b1);
    check(word === 16'h8001, "R10", "word after idle toggles", word, 16'h8001);

    // R8: reset mid-run clears output
    do_reset();
    check(word === 16'h0, "R8", "output cleared by reset", word, 16'h0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule